// File: doc/BRIEF.md
# Masked Shuffle Program Sequencer

This block is the control side of an array of N = 2^M processing elements linked by a plus-minus-2^i network. After a start pulse it broadcasts a fixed program of commands, one per clock cycle. When the elements execute that program, the word in each element's transfer register moves to the element whose address is the original address rotated left by one bit. That permutation is the perfect shuffle. The program needs M+1 network transfers and M+1 register moves. The block does not execute the commands and never sees the data.

Each command carries four things:
- an opcode;
- a ternary address mask, coded as a care vector and a value vector;
- for transfers, a direction bit and a distance index i, where the distance is 2^i.

An element takes part in a command when ((address XOR value) AND care) is zero. The command fields are valid for one cycle each and are all zero between commands. A one-cycle done pulse follows the last command.

Top module: `pm2_shuffle_seq`

## Requirements
- R1: While rst is high at a clock edge, and at every edge after it until a start is accepted, cmd_valid and done are low.
- R2: A start sampled high while idle makes cmd_valid go high in the next cycle. It then stays high for exactly 2M+2 consecutive cycles, and each of those cycles carries the next command in order.
- R3: Opcodes are 0 = copy transfer register into A, 1 = copy A into transfer register, 2 = exchange A and transfer register, 3 = network transfer. Command 0 is opcode 0 on even elements (care=1, value=0). Command 1 is a +2^0 transfer on odd elements (care=1, value=1).
- R4: For j = 1 up to M-1, command 2j is an exchange with care = 2^j+1 and value = 2^j, meaning bit j is 1 and bit 0 is 0. Command 2j+1 is a +2^j transfer on even elements (care=1, value=0).
- R5: Command 2M is a +2^0 transfer on even elements. Command 2M+1, the last one, is opcode 1 on even elements.
- R6: cmd_care and cmd_value select the elements where ((addr ^ value) & care) == 0. For an exchange this is exactly N/4 elements.
- R7: Each run issues exactly M+1 transfers and M+1 register moves (opcodes 0, 1 and 2). Every transfer has cmd_neg = 0, meaning plus. On non-transfer commands, cmd_neg and cmd_idx are 0.
- R8: done is high for exactly one cycle: the cycle right after the last command. cmd_valid is low in that cycle.
- R9: A start while commands are being issued, or in the done cycle, is ignored. It neither lengthens nor restarts the run.
- R10: A synchronous reset in the middle of a run returns the block to idle in the next cycle. A later start then runs the full program from command 0.
- R11: An N-element array that executes the issued commands ends with the word that started in element p located in the transfer register of element ((2p) mod N) + (p >> (M-1)).
- R12: Whenever cmd_valid is low, cmd_op, cmd_care, cmd_value, cmd_neg and cmd_idx are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run request, accepted only when idle |
| cmd_valid | output | 1 | Command fields valid this cycle |
| cmd_op | output | 2 | Opcode (encoding in R3) |
| cmd_care | output | M | Mask positions that are checked |
| cmd_value | output | M | Required address bit values at the checked positions |
| cmd_neg | output | 1 | Transfer direction, 0 = plus |
| cmd_idx | output | max(1,clog2(M)) | Transfer distance exponent i |
| done | output | 1 | One-cycle pulse after the last command |

## Verification
The bench builds two copies of the block side by side, one with M = 4 (16 elements) and one with M = 2 (4 elements). Both receive the same start and reset pattern. Because their runs differ in length, the same stimulus reaches each copy at a different point in its program, including the done cycle.

M = 4 exercises a loop with three iterations and a distance index that needs two bits. M = 2 is the smallest legal size: its loop has a single iteration, and its tail commands sit right next to the head commands.

A behavioural model of an element array executes every issued command for both sizes. It checks that the shuffle comes out at the end of each run.

// File: rtl/pm2_shuffle_pkg.sv
package pm2_shuffle_pkg;

   typedef enum logic [1:0] {
      OP_D2A  = 2'd0,
      OP_A2D  = 2'd1,
      OP_SWAP = 2'd2,
      OP_XFER = 2'd3
   } shf_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } shf_state_e;

   function automatic int unsigned idx_width(input int unsigned m);
      return (m > 1) ? $clog2(m) : 1;
   endfunction

   function automatic int unsigned step_width(input int unsigned m);
      return $clog2(2 * m + 3);
   endfunction

endpackage

// File: rtl/pm2_seq_ctrl.sv
module pm2_seq_ctrl
   import pm2_shuffle_pkg::*;
#(
   parameter int unsigned M = 3,
   localparam int unsigned STEPS = 2 * M + 2,
   localparam int unsigned SW = step_width(M)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   output logic          run,
   output logic          fin,
   output logic [SW-1:0] step
);

   localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

   shf_state_e    state_q;
   logic [SW-1:0] step_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               step_q <= '0;
               if (start) state_q <= ST_RUN;
            end
            ST_RUN: begin
               if (step_q == LAST) begin
                  state_q <= ST_FIN;
                  step_q  <= '0;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               step_q  <= '0;
            end
         endcase
      end
   end

   assign run  = (state_q == ST_RUN);
   assign fin  = (state_q == ST_FIN);
   assign step = step_q;

endmodule

// File: rtl/pm2_step_decode.sv
module pm2_step_decode
   import pm2_shuffle_pkg::*;
#(
   parameter int unsigned M = 3,
   localparam int unsigned STEPS = 2 * M + 2,
   localparam int unsigned SW = step_width(M),
   localparam int unsigned IW = idx_width(M)
) (
   input  logic          run,
   input  logic [SW-1:0] step,
   output shf_op_e       op,
   output logic [M-1:0]  care,
   output logic [M-1:0]  value,
   output logic          neg,
   output logic [IW-1:0] idx
);

   localparam logic [M-1:0]  BIT0    = M'(1);
   localparam logic [SW-1:0] S_HEAD1 = SW'(1);
   localparam logic [SW-1:0] S_TAIL0 = SW'(STEPS - 2);
   localparam logic [SW-1:0] S_TAIL1 = SW'(STEPS - 1);

   logic [SW-1:0] loop_j;
   logic [M-1:0]  loop_hot;
   logic [IW-1:0] loop_idx;

   assign loop_j = step >> 1;

   for (genvar g = 0; g < M; g++) begin : g_hot
      assign loop_hot[g] = (loop_j == SW'(g));
   end

   always_comb begin
      loop_idx = '0;
      for (int g = 0; g < M; g++) begin
         if (loop_hot[g]) loop_idx = IW'(g);
      end
   end

   always_comb begin
      op    = OP_D2A;
      care  = '0;
      value = '0;
      neg   = 1'b0;
      idx   = '0;
      if (run) begin
         care = BIT0;
         if (step == '0) begin
            op = OP_D2A;
         end else if (step == S_HEAD1) begin
            op    = OP_XFER;
            value = BIT0;
         end else if (step == S_TAIL0) begin
            op = OP_XFER;
         end else if (step == S_TAIL1) begin
            op = OP_A2D;
         end else if (!step[0]) begin
            op    = OP_SWAP;
            care  = loop_hot | BIT0;
            value = loop_hot;
         end else begin
            op  = OP_XFER;
            idx = loop_idx;
         end
      end
   end

endmodule

// File: rtl/pm2_shuffle_seq.sv
module pm2_shuffle_seq
   import pm2_shuffle_pkg::*;
#(
   parameter int unsigned M = 3,
   localparam int unsigned SW = step_width(M),
   localparam int unsigned IW = idx_width(M)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   output logic          cmd_valid,
   output logic [1:0]    cmd_op,
   output logic [M-1:0]  cmd_care,
   output logic [M-1:0]  cmd_value,
   output logic          cmd_neg,
   output logic [IW-1:0] cmd_idx,
   output logic          done
);

   if (M < 2 || M > 6) begin : g_bad_m
      $error("pm2_shuffle_seq: M must lie in 2..6");
   end

   logic          run_w;
   logic          fin_w;
   logic [SW-1:0] step_w;
   shf_op_e       op_w;

   pm2_seq_ctrl #(.M(M)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .run   (run_w),
      .fin   (fin_w),
      .step  (step_w)
   );

   pm2_step_decode #(.M(M)) u_dec (
      .run   (run_w),
      .step  (step_w),
      .op    (op_w),
      .care  (cmd_care),
      .value (cmd_value),
      .neg   (cmd_neg),
      .idx   (cmd_idx)
   );

   assign cmd_valid = run_w;
   assign cmd_op    = op_w;
   assign done      = fin_w;

endmodule

// File: rtl/pm2_shuffle_seq_chk.sv
module pm2_shuffle_seq_chk
   import pm2_shuffle_pkg::*;
#(
   parameter int unsigned M = 3,
   localparam int unsigned STEPS = 2 * M + 2,
   localparam int unsigned SW = step_width(M),
   localparam int unsigned IW = idx_width(M)
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic          cmd_valid,
   input logic [1:0]    cmd_op,
   input logic [M-1:0]  cmd_care,
   input logic [M-1:0]  cmd_value,
   input logic          cmd_neg,
   input logic [IW-1:0] cmd_idx,
   input logic          done
);

   logic [SW-1:0] run_len;
   logic [SW-1:0] xfer_cnt;

   always_ff @(posedge clk) begin
      if (rst || done) begin
         run_len  <= '0;
         xfer_cnt <= '0;
      end else if (cmd_valid) begin
         run_len <= run_len + 1'b1;
         if (cmd_op == OP_XFER) xfer_cnt <= xfer_cnt + 1'b1;
      end
   end

   assert_start_R2: assert property (@(posedge clk) disable iff (rst)
      (start && !cmd_valid && !done) |=> cmd_valid);

   assert_run_len_R2: assert property (@(posedge clk) disable iff (rst)
      done |-> (run_len == SW'(STEPS)));

   assert_xfer_count_R7: assert property (@(posedge clk) disable iff (rst)
      done |-> (xfer_cnt == SW'(M + 1)));

   assert_plus_only_R7: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |-> (!cmd_neg && (cmd_op == OP_XFER || cmd_idx == '0)));

   assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |-> (32'(cmd_idx) < M));

   assert_swap_mask_R6: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == OP_SWAP) |->
         ($countones(cmd_care) == 2 && cmd_care[0] && !cmd_value[0]
          && $countones(cmd_value) == 1));

   assert_bit0_mask_R6: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op != OP_SWAP) |-> (cmd_care == M'(1)));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> (!cmd_valid && $past(cmd_valid)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |-> (cmd_op == 2'd0 && cmd_care == '0 && cmd_value == '0
                      && !cmd_neg && cmd_idx == '0));

   assert_reset_idle_R10: assert property (@(posedge clk)
      rst |=> (!cmd_valid && !done));

endmodule

bind pm2_shuffle_seq pm2_shuffle_seq_chk #(.M(M)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_care  (cmd_care),
   .cmd_value (cmd_value),
   .cmd_neg   (cmd_neg),
   .cmd_idx   (cmd_idx),
   .done      (done)
);

// File: tb/pm2_shuffle_seq_tb.sv
module pm2_shuffle_seq_tb;

   localparam int MA  = 4;
   localparam int MB  = 2;
   localparam int IWA = 2;
   localparam int IWB = 1;

   logic clk = 1'b0;
   logic rst;
   logic start;
   always #10 clk = ~clk;

   logic           va, da, na;
   logic [1:0]     opa;
   logic [MA-1:0]  ca, wa;
   logic [IWA-1:0] ia;
   logic           vb, db, nb;
   logic [1:0]     opb;
   logic [MB-1:0]  cb, wb;
   logic [IWB-1:0] ib;

   pm2_shuffle_seq #(.M(MA)) u_dut (
      .clk(clk), .rst(rst), .start(start), .cmd_valid(va), .cmd_op(opa),
      .cmd_care(ca), .cmd_value(wa), .cmd_neg(na), .cmd_idx(ia), .done(da));

   pm2_shuffle_seq #(.M(MB)) u_dut_m2 (
      .clk(clk), .rst(rst), .start(start), .cmd_valid(vb), .cmd_op(opb),
      .cmd_care(cb), .cmd_value(wb), .cmd_neg(nb), .cmd_idx(ib), .done(db));

   int    total = 0;
   int    bad   = 0;
   bit    ended = 0;
   string ctx   = "R1";

   int mst[2];
   int mk[2];
   int xf[2];
   int mv[2];
   int pa[2][64];
   int pd[2][64];

   function automatic int msize(input int s);
      return (s == 0) ? MA : MB;
   endfunction

   task automatic exp_cmd(input int m, input int k,
                          output int op, output int care, output int val,
                          output int idx);
      idx = 0; care = 1; val = 0;
      if (k == 0) op = 0;
      else if (k == 1) begin op = 3; val = 1; end
      else if (k == 2 * m) op = 3;
      else if (k == 2 * m + 1) op = 1;
      else if (k % 2 == 0) begin
         op = 2; care = (1 << (k / 2)) | 1; val = 1 << (k / 2);
      end else begin
         op = 3; idx = k / 2;
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      for (int s = 0; s < 2; s++) begin
         if (rst) begin
            mst[s] = 0; mk[s] = 0;
         end else begin
            case (mst[s])
               0: if (start) begin
                  mst[s] = 1; mk[s] = 0; xf[s] = 0; mv[s] = 0;
                  for (int p = 0; p < 64; p++) begin
                     pd[s][p] = p; pa[s][p] = -1;
                  end
               end
               1: if (mk[s] == 2 * msize(s) + 1) mst[s] = 2;
                  else mk[s] = mk[s] + 1;
               default: mst[s] = 0;
            endcase
         end
      end
   end

   task automatic emulate(input int s, input int op, input int care,
                          input int val, input int idx);
      int n;
      int act;
      int tmp;
      int nd[64];
      n = 1 << msize(s);
      act = 0;
      for (int p = 0; p < 64; p++) nd[p] = pd[s][p];
      for (int p = 0; p < n; p++) begin
         if (((p ^ val) & care) == 0) begin
            act++;
            case (op)
               0: pa[s][p] = pd[s][p];
               1: pd[s][p] = pa[s][p];
               2: begin tmp = pa[s][p]; pa[s][p] = pd[s][p]; pd[s][p] = tmp; end
               default: nd[(p + (1 << idx)) % n] = pd[s][p];
            endcase
         end
      end
      if (op == 3) for (int p = 0; p < 64; p++) pd[s][p] = nd[p];
      if (op == 3) xf[s]++; else mv[s]++;
      if (op == 2) begin
         total++;
         if (act != n / 4) begin
            bad++;
            $display("FAIL R6 dut%0d exchange enables %0d elements, expected %0d",
                     s, act, n / 4);
         end
      end
   endtask

   task automatic finish_run(input int s);
      int m, n, miss, q;
      m = msize(s);
      n = 1 << m;
      total++;
      if (xf[s] != m + 1 || mv[s] != m + 1) begin
         bad++;
         $display("FAIL R7 dut%0d transfers=%0d moves=%0d expected %0d and %0d",
                  s, xf[s], mv[s], m + 1, m + 1);
      end
      miss = 0;
      for (int p = 0; p < n; p++) begin
         q = ((p << 1) | (p >> (m - 1))) & (n - 1);
         if (pd[s][q] != p) miss++;
      end
      total++;
      if (miss != 0) begin
         bad++;
         $display("FAIL R11 R6 dut%0d %0d elements misplaced, expected 0",
                  s, miss);
      end
   endtask

   task automatic cmp(input int s, input int v, input int dn, input int op,
                      input int care, input int val, input int ng,
                      input int idx);
      int ev, edn, eop, ecare, eval, eidx, m;
      string tag;
      m = msize(s);
      ev = 0; edn = 0; eop = 0; ecare = 0; eval = 0; eidx = 0;
      if (mst[s] == 1) begin
         ev = 1;
         exp_cmd(m, mk[s], eop, ecare, eval, eidx);
         tag = (mk[s] < 2) ? "R2 R3" : (mk[s] >= 2 * m) ? "R2 R5" : "R2 R4";
      end else if (mst[s] == 2) begin
         edn = 1; tag = "R8";
      end else begin
         tag = "R1 R12";
      end
      total++;
      if (v != ev || dn != edn || op != eop || care != ecare || val != eval
          || ng != 0 || idx != eidx) begin
         bad++;
         $display("FAIL %s (%s) dut%0d got v=%0d done=%0d op=%0d care=%0h val=%0h neg=%0d idx=%0d expected v=%0d done=%0d op=%0d care=%0h val=%0h neg=0 idx=%0d",
                  tag, ctx, s, v, dn, op, care, val, ng, idx,
                  ev, edn, eop, ecare, eval, eidx);
      end
      if (v == 1) emulate(s, op, care, val, idx);
      if (dn == 1 && edn == 1) finish_run(s);
   endtask

   always @(negedge clk) begin
      cmp(0, int'(va), int'(da), int'(opa), int'(ca), int'(wa), int'(na), int'(ia));
      cmp(1, int'(vb), int'(db), int'(opb), int'(cb), int'(wb), int'(nb), int'(ib));
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   initial begin
      rst = 1'b1; start = 1'b0;
      wait_cyc(3);
      rst = 1'b0;
      wait_cyc(3);
      ctx = "R2";
      pulse_start();
      wait_cyc(20);
      ctx = "R9";
      pulse_start();
      wait_cyc(3);
      pulse_start();
      pulse_start();
      wait_cyc(1);
      pulse_start();
      pulse_start();
      pulse_start();
      wait_cyc(20);
      ctx = "R10";
      pulse_start();
      wait_cyc(4);
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      wait_cyc(3);
      pulse_start();
      wait_cyc(20);
      ctx = "R9";
      @(negedge clk) start = 1'b1;
      wait_cyc(60);
      start = 1'b0;
      wait_cyc(20);
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R2 watchdog expired: run not finished, expected summary before 200000 cycles");
      summary();
   end

endmodule